// File: doc/BRIEF.md
# Effective Address and Alignment Unit

This unit forms the 32-bit address of a memory operand or a branch target. A 3-bit mode input chooses how the address is made. The three load/store modes use a base register plus a signed immediate, a base register plus an index register, or the base register alone. The three branch modes use a relative-or-absolute displacement, the link register, or the count register. Every address is a plain unsigned sum modulo 2^32.

A 2-bit size code gives the operand length. The unit reports two flags against that length. The misalign flag is set when the address is not a multiple of the length. The wrap flag is set when the operand's last byte would fall past the top of the address space and so continue from address 0. The unit does not act on either flag. A later exception stage decides what to do.

Requests arrive on a valid/ready stream and results leave on another, through a single output register. A request is accepted when `in_valid` and `in_ready` are both high. The result appears with `out_valid` on the next cycle. It stays on the outputs, unchanged, until the consumer raises `out_ready`. `in_ready` is high whenever the output register is empty or is being drained in the same cycle, so results can flow one per cycle with no gap.

Top module: `ea_align_unit`

## Requirements
- R1: Load/store modes, selected by `in_mode`: 0 gives base+immediate, 1 gives base+index and 2 gives base alone. Sums are taken modulo 2^32, and the carry out of bit 31 is dropped.
- R2: Mode 3 (branch displacement) gives `in_cia`+`in_imm` when `in_abs`=0, and `in_imm` alone when `in_abs`=1.
- R3: Mode 4 gives `in_lr` and mode 5 gives `in_ctr`, each with bits [1:0] forced to 0.
- R4: The unused mode codes 6 and 7 behave exactly like mode 2 (base alone).
- R5: Size codes are 0=1 byte, 1=2 bytes, 2=4 bytes and 3=8 bytes. `out_misalign` is 1 exactly when any of the low `in_size` address bits is set. A 1-byte access is therefore never misaligned.
- R6: `out_wrap` is 1 exactly when the address plus the operand length exceeds 2^32, that is, when the last byte lies beyond 0xFFFFFFFF.
- R7: The result of a request accepted at a clock edge is presented with `out_valid`=1 after that edge. `in_ready` equals (not `out_valid`) or `out_ready`. Each accepted request yields exactly one output transfer.
- R8: While `out_valid`=1 and `out_ready`=0, `out_valid`, `out_ea`, `out_misalign` and `out_wrap` hold their values.
- R9: During and right after reset, `out_valid`=0 and `in_ready`=1.
- R10: `in_abs` has no effect in any mode other than 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| in_mode | input | 3 | Address mode (R1 to R4) |
| in_abs | input | 1 | Absolute select for mode 3 |
| in_size | input | 2 | Operand size code |
| in_base | input | 32 | Base register value |
| in_index | input | 32 | Index register value |
| in_imm | input | 32 | Sign-extended immediate or displacement |
| in_lr | input | 32 | Link register value |
| in_ctr | input | 32 | Count register value |
| in_cia | input | 32 | Address of the current instruction |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_ea | output | 32 | Effective address |
| out_misalign | output | 1 | Address not a multiple of the operand length |
| out_wrap | output | 1 | Operand extends past the top of the address space |

## Verification
The bench aims at the top of the address space. A base of 0xFFFFFFF0 plus 0x20 must give 0x10; a design that kept the carry or saturated would report the wrong address. Near 0xFFFFFFF8 the bench uses every size, where an off-by-one wrap compare would flag an 8-byte operand that ends exactly at 0xFFFFFFFF, or miss a 2-byte operand at 0xFFFFFFFF. Link and count targets with low bits set would expose a missing clear. Long stalls mixed with back-to-back transfers would show a result that changes while held, or a request that is lost or repeated.

// File: rtl/eau_pkg.sv
package eau_pkg;
  localparam logic [2:0] MODE_LS_IMM = 3'd0;
  localparam logic [2:0] MODE_LS_IDX = 3'd1;
  localparam logic [2:0] MODE_LS_REG = 3'd2;
  localparam logic [2:0] MODE_BR_DSP = 3'd3;
  localparam logic [2:0] MODE_BR_LNK = 3'd4;
  localparam logic [2:0] MODE_BR_CNT = 3'd5;
endpackage

// File: rtl/eau_addr_gen.sv
module eau_addr_gen #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned CLR_BITS  = 2
) (
  input  logic [2:0]        mode,
  input  logic              abs_sel,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] idx,
  input  logic [ADDR_W-1:0] imm,
  input  logic [ADDR_W-1:0] lr,
  input  logic [ADDR_W-1:0] ctr,
  input  logic [ADDR_W-1:0] cia,
  output logic [ADDR_W-1:0] ea
);
  import eau_pkg::*;

  localparam logic [ADDR_W-1:0] LOW_ONES = ADDR_W'((1 << CLR_BITS) - 1);
  localparam logic [ADDR_W-1:0] KEEP_HI  = ~LOW_ONES;

  logic [ADDR_W-1:0] opa;
  logic [ADDR_W-1:0] opb;

  // Operand select feeding one shared modulo-2^N adder.
  always_comb begin
    opa = base;
    opb = '0;
    case (mode)
      MODE_LS_IMM: begin opa = base; opb = imm; end
      MODE_LS_IDX: begin opa = base; opb = idx; end
      MODE_BR_DSP: begin opa = abs_sel ? '0 : cia; opb = imm; end
      MODE_BR_LNK: begin opa = lr & KEEP_HI; opb = '0; end
      MODE_BR_CNT: begin opa = ctr & KEEP_HI; opb = '0; end
      default:     begin opa = base; opb = '0; end
    endcase
  end

  assign ea = opa + opb;
endmodule

// File: rtl/eau_align_chk.sv
module eau_align_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned SIZE_W = 2
) (
  input  logic [ADDR_W-1:0] ea,
  input  logic [SIZE_W-1:0] size,
  output logic              misalign,
  output logic              wrap
);
  localparam int unsigned MAX_SH = (1 << SIZE_W) - 1;
  localparam int unsigned LEN_W  = MAX_SH + 1;

  logic [MAX_SH-1:0] low_mask;
  logic [LEN_W-1:0]  len;
  logic [ADDR_W:0]   span_end;

  // One mask bit per address bit that a larger size must see clear.
  for (genvar gi = 0; gi < MAX_SH; gi++) begin : g_mask
    assign low_mask[gi] = (size > SIZE_W'(gi));
  end

  assign misalign = |(ea[MAX_SH-1:0] & low_mask);
  assign len      = LEN_W'(1) << size;
  assign span_end = {1'b0, ea} + (ADDR_W+1)'(len);
  // Beyond 2^N exactly when the top bit is set and any lower bit is set.
  assign wrap     = span_end[ADDR_W] & (|span_end[ADDR_W-1:0]);
endmodule

// File: rtl/eau_out_reg.sv
module eau_out_reg #(
  parameter int unsigned W = 34
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         up_valid,
  output logic         up_ready,
  input  logic [W-1:0] up_data,
  output logic         dn_valid,
  input  logic         dn_ready,
  output logic [W-1:0] dn_data
);
  assign up_ready = !dn_valid || dn_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dn_valid <= 1'b0;
      dn_data  <= '0;
    end else if (up_ready) begin
      dn_valid <= up_valid;
      if (up_valid) dn_data <= up_data;
    end
  end

  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid && !dn_ready |=> dn_valid && $stable(dn_data));
  a_r7_accept_gives_beat: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid && up_ready |=> dn_valid);
  a_r7_beat_needs_accept: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dn_valid) |-> $past(up_valid && up_ready));
endmodule

// File: rtl/ea_align_unit.sv
module ea_align_unit #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned SIZE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [2:0]        in_mode,
  input  logic              in_abs,
  input  logic [SIZE_W-1:0] in_size,
  input  logic [ADDR_W-1:0] in_base,
  input  logic [ADDR_W-1:0] in_index,
  input  logic [ADDR_W-1:0] in_imm,
  input  logic [ADDR_W-1:0] in_lr,
  input  logic [ADDR_W-1:0] in_ctr,
  input  logic [ADDR_W-1:0] in_cia,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_ea,
  output logic              out_misalign,
  output logic              out_wrap
);
  import eau_pkg::*;

  localparam int unsigned PAY_W = ADDR_W + 2;

  logic [ADDR_W-1:0] ea_c;
  logic              mis_c;
  logic              wrap_c;
  logic [PAY_W-1:0]  pay_q;

  eau_addr_gen #(.ADDR_W(ADDR_W), .CLR_BITS(2)) u_gen (
    .mode(in_mode), .abs_sel(in_abs), .base(in_base), .idx(in_index),
    .imm(in_imm), .lr(in_lr), .ctr(in_ctr), .cia(in_cia), .ea(ea_c)
  );

  eau_align_chk #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_chk (
    .ea(ea_c), .size(in_size), .misalign(mis_c), .wrap(wrap_c)
  );

  eau_out_reg #(.W(PAY_W)) u_out (
    .clk(clk), .rst_n(rst_n),
    .up_valid(in_valid), .up_ready(in_ready), .up_data({ea_c, mis_c, wrap_c}),
    .dn_valid(out_valid), .dn_ready(out_ready), .dn_data(pay_q)
  );

  assign out_ea       = pay_q[PAY_W-1:2];
  assign out_misalign = pay_q[1];
  assign out_wrap     = pay_q[0];

  a_r5_byte_never_misaligned: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_size == '0 |-> !mis_c);
  a_r6_byte_wraps_never: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_size == '0 |-> !wrap_c);
  a_r3_reg_target_low_clear: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (in_mode == MODE_BR_LNK || in_mode == MODE_BR_CNT) |-> ea_c[1:0] == 2'b00);
  a_r9_empty_after_reset: assert property (@(posedge clk)
    !rst_n |=> !out_valid);
endmodule

// File: tb/sim_ea_align_unit.sv
module sim_ea_align_unit;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_abs = 1'b0, out_ready = 1'b0;
  logic in_ready, out_valid, out_misalign, out_wrap;
  logic [2:0] in_mode = '0;
  logic [1:0] in_size = '0;
  logic [31:0] in_base = '0, in_index = '0, in_imm = '0, in_lr = '0, in_ctr = '0, in_cia = '0;
  logic [31:0] out_ea;

  ea_align_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_mode(in_mode), .in_abs(in_abs), .in_size(in_size), .in_base(in_base),
    .in_index(in_index), .in_imm(in_imm), .in_lr(in_lr), .in_ctr(in_ctr),
    .in_cia(in_cia), .out_valid(out_valid), .out_ready(out_ready),
    .out_ea(out_ea), .out_misalign(out_misalign), .out_wrap(out_wrap)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // Reference state: one held result, or none.
  bit m_valid = 0;
  logic [31:0] m_ea;
  bit m_mis, m_wrap;
  logic [2:0] m_mode;
  bit m_abs;
  bit held_prev = 0;
  logic [31:0] last_ea;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic string ea_req(input logic [2:0] m, input bit ab);
    if (m == 3'd3) return "R2";
    if (m == 3'd4 || m == 3'd5) return "R3";
    if (m >= 3'd6) return "R4";
    return ab ? "R10" : "R1";
  endfunction

  task automatic ref_calc(output logic [31:0] ea, output bit mis, output bit wr);
    longint unsigned t;
    longint unsigned len;
    case (in_mode)
      3'd0: t = longint'(in_base) + longint'(in_imm);
      3'd1: t = longint'(in_base) + longint'(in_index);
      3'd3: t = in_abs ? longint'(in_imm) : longint'(in_cia) + longint'(in_imm);
      3'd4: t = longint'(in_lr) - (longint'(in_lr) % 4);
      3'd5: t = longint'(in_ctr) - (longint'(in_ctr) % 4);
      default: t = longint'(in_base);
    endcase
    t = t % 64'h1_0000_0000;
    ea = t[31:0];
    len = 64'd1 << in_size;
    mis = (t % len) != 0;
    wr = (t + len) > 64'h1_0000_0000;
  endtask

  task automatic cycle(input bit v, input logic [2:0] m, input bit ab, input logic [1:0] s,
                       input logic [31:0] b, input logic [31:0] x, input logic [31:0] i,
                       input logic [31:0] l, input logic [31:0] c, input logic [31:0] p,
                       input bit ordy);
    bit acc;
    @(negedge clk);
    check(out_valid == m_valid, "R7", "out_valid", out_valid, m_valid);
    if (m_valid) begin
      check(out_ea == m_ea, ea_req(m_mode, m_abs), "out_ea", out_ea, m_ea);
      check(out_misalign == m_mis, "R5", "out_misalign", out_misalign, m_mis);
      check(out_wrap == m_wrap, "R6", "out_wrap", out_wrap, m_wrap);
    end
    if (held_prev)
      check(out_ea == last_ea && out_valid, "R8", "held out_ea", out_ea, last_ea);
    last_ea = out_ea;
    in_valid = v; in_mode = m; in_abs = ab; in_size = s; in_base = b; in_index = x;
    in_imm = i; in_lr = l; in_ctr = c; in_cia = p; out_ready = ordy;
    #1;
    check(in_ready == (!m_valid || ordy), "R7", "in_ready", in_ready, !m_valid || ordy);
    acc = v && (!m_valid || ordy);
    held_prev = m_valid && !ordy;
    @(posedge clk);
    if (acc) begin
      ref_calc(m_ea, m_mis, m_wrap);
      m_mode = m; m_abs = ab; m_valid = 1;
    end else if (m_valid && ordy) begin
      m_valid = 0;
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL R7 watchdog expired actual=0 expected=1");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(out_valid == 1'b0, "R9", "out_valid in reset", out_valid, 0);
    check(in_ready == 1'b1, "R9", "in_ready in reset", in_ready, 1);
    rst_n = 1'b1;
    #1;
    check(in_ready == 1'b1, "R9", "in_ready after reset", in_ready, 1);

    // R1 carry out of bit 31 dropped; three load/store modes.
    cycle(1, 3'd0, 0, 2'd0, 32'hFFFF_FFF0, 0, 32'h20, 0, 0, 0, 1);
    cycle(1, 3'd1, 0, 2'd2, 32'h1000, 32'h0000_0204, 0, 0, 0, 0, 1);
    cycle(1, 3'd2, 0, 2'd3, 32'h0000_8008, 32'h55, 32'h77, 0, 0, 0, 1);
    cycle(1, 3'd0, 0, 2'd1, 32'h100, 0, 32'hFFFF_FFFF, 0, 0, 0, 1);
    // R2 relative and absolute displacement.
    cycle(1, 3'd3, 0, 2'd2, 0, 0, 32'hFFFF_FFF8, 0, 0, 32'h0000_0100, 1);
    cycle(1, 3'd3, 1, 2'd2, 0, 0, 32'h0000_0400, 0, 0, 32'h0000_0100, 1);
    // R3 link and count low bits cleared.
    cycle(1, 3'd4, 0, 2'd2, 0, 0, 0, 32'h0000_1003, 32'h9, 0, 1);
    cycle(1, 3'd5, 0, 2'd2, 0, 0, 0, 32'h3, 32'hABCD_EF07, 0, 1);
    // R4 reserved modes.
    cycle(1, 3'd6, 0, 2'd0, 32'h1234_5677, 32'h1, 32'h2, 32'h3, 32'h4, 32'h5, 1);
    cycle(1, 3'd7, 1, 2'd0, 32'h0000_0013, 32'h1, 32'h2, 32'h3, 32'h4, 32'h5, 1);
    // R10 absolute select ignored outside mode 3.
    cycle(1, 3'd0, 1, 2'd2, 32'h2000, 0, 32'h10, 0, 0, 32'h9000, 1);
    cycle(1, 3'd4, 1, 2'd2, 0, 0, 32'h40, 32'h88, 0, 32'h9000, 1);
    // R5 and R6 at the top of the space, every size.
    for (int k = 0; k < 4; k++) begin
      cycle(1, 3'd2, 0, k[1:0], 32'hFFFF_FFF8, 0, 0, 0, 0, 0, 1);
      cycle(1, 3'd2, 0, k[1:0], 32'hFFFF_FFFC, 0, 0, 0, 0, 0, 1);
      cycle(1, 3'd2, 0, k[1:0], 32'hFFFF_FFFF, 0, 0, 0, 0, 0, 1);
      cycle(1, 3'd2, 0, k[1:0], 32'h0000_0006, 0, 0, 0, 0, 0, 1);
    end
    // R8 stall with a pending request behind it.
    cycle(1, 3'd1, 0, 2'd3, 32'h10, 32'h3, 0, 0, 0, 0, 1);
    cycle(1, 3'd0, 0, 2'd1, 32'h20, 0, 32'h1, 0, 0, 0, 0);
    cycle(1, 3'd0, 0, 2'd1, 32'h30, 0, 32'h1, 0, 0, 0, 0);
    cycle(1, 3'd0, 0, 2'd1, 32'h40, 0, 32'h1, 0, 0, 0, 0);
    cycle(0, 3'd0, 0, 2'd0, 0, 0, 0, 0, 0, 0, 1);
    cycle(0, 3'd0, 0, 2'd0, 0, 0, 0, 0, 0, 0, 1);

    for (int n = 0; n < 3000; n++) begin
      logic [31:0] rb;
      rb = ($urandom_range(0, 3) == 0) ? (32'hFFFF_FFF0 | 32'($urandom_range(0, 15))) : $urandom;
      cycle($urandom_range(0, 9) < 8, 3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)),
            2'($urandom_range(0, 3)), rb, $urandom, $urandom, $urandom, $urandom, $urandom,
            $urandom_range(0, 3) != 0);
    end
    cycle(0, 3'd0, 0, 2'd0, 0, 0, 0, 0, 0, 0, 1);
    cycle(0, 3'd0, 0, 2'd0, 0, 0, 0, 0, 0, 0, 1);

    done = 1;
    summary();
    $finish;
  end
endmodule